// File: doc/BRIEF.md
# Multiplexed ADC Conversion Controller

This block drives an external eight-input successive-approximation converter that has an analog multiplexer in front of it. A divider turns the system clock into a sampling tick. On each tick that finds the controller idle, it puts a 3-bit channel number on the address pins. It latches that number into the converter with a pulse, then holds start-of-conversion high for a fixed number of clocks and drops it. It waits for the converter to report end of conversion, then drives output enable for a fixed number of clocks. The result byte is captured as output enable falls.

The captured byte comes out with a one-clock valid strobe and the channel it belongs to. The channel comes either from a select input or from an internal scan counter that cycles through the first few channels. If end of conversion never arrives, a timeout abandons the conversion and raises an error flag. The flag stays up until the next conversion begins.

Top module: `adc_conv_ctrl`

## Requirements
- R1: While reset is low, ale, soc, oe, dataValid and errFlag are 0, and adcAddr, dataOut and validChan are 0.
- R2: A sampling tick occurs every TICK_DIV clocks. A conversion starts on a tick only if the controller is idle, and a tick that arrives while a conversion is in progress is dropped. Consecutive conversions therefore start TICK_DIV clocks apart when each one finishes within TICK_DIV clocks, and 2*TICK_DIV clocks apart when one takes between TICK_DIV and 2*TICK_DIV clocks.
- R3: A conversion proceeds in a fixed order. The address is valid for one clock with ale low, then ale is high for exactly ALE_W clocks. soc rises on the same clock on which ale falls and is high for exactly SOC_W clocks. adcAddr does not change from the rise of ale until the sample is captured.
- R4: After soc falls, the controller waits for eocIn to be high. oe rises on the clock after eocIn is first seen high, and never without eocIn having been high on the previous clock.
- R5: oe is high for exactly OE_W clocks. dataOut takes the value on adcData during the last clock of oe, and it updates on the edge where oe falls.
- R6: dataValid is high for one clock and goes high on the same edge on which dataOut updates. validChan carries the address used for that conversion.
- R7: If eocIn is not high within EOC_TIMEOUT clocks of waiting, the controller returns to idle without any oe pulse and without dataValid, and sets errFlag. errFlag stays set until the next conversion starts, and it clears on the edge that loads the new address.
- R8: With autoScan = 0, the address of a conversion is the value on chanSel when that conversion starts.
- R9: With autoScan = 1, chanSel is ignored. The address is taken from a scan index that starts at 0 after reset, counts 0, 1, ... SCAN_CHANS-1 and then wraps to 0. The index advances once for each captured sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| eocIn | input | 1 | End of conversion from the converter, high when the result is ready |
| adcData | input | DATA_W | Result bus from the converter |
| chanSel | input | CH_W | Channel number used when scanning is off |
| autoScan | input | 1 | 1 selects the internal scan index as the channel source |
| adcAddr | output | CH_W | Multiplexer address to the converter |
| ale | output | 1 | Address latch pulse |
| soc | output | 1 | Start-of-conversion pulse |
| oe | output | 1 | Output enable pulse to the converter |
| dataOut | output | DATA_W | Last captured result |
| dataValid | output | 1 | One-clock strobe that marks a new result |
| validChan | output | CH_W | Channel of the result on dataOut |
| errFlag | output | 1 | Set by an end-of-conversion timeout |

## Verification
The converter model answers every start pulse after a programmed delay and returns a byte built from the channel and a sequence number. A scoreboard then checks each captured value against the byte that was actually driven while output enable was high. Short delays show that the handshake order and the pulse widths are right, and they give the base tick spacing. A delay longer than the tick period shows that ticks are dropped while busy, because the spacing doubles. A converter that never answers exercises the timeout, and the bench checks that no read pulse or result follows it and that the flag clears on the next start. Runs in scan mode and in select mode, with different select values, tell the two channel sources apart, and in scan mode the bench confirms that the wrap and the ignored select input behave as required.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LATCH,
    ST_START,
    ST_WAIT,
    ST_READ
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;  // start of a conversion: pick channel, clear error
    logic capture;   // last oe clock: take adcData
    logic timeout;   // end-of-conversion wait expired
  } ctrlStrobe_t;

endpackage

// File: rtl/adcc_tick.sv
module adcc_tick #(
  parameter int TICK_DIV = 5000
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int DIV = (TICK_DIV < 2) ? 2 : TICK_DIV;
  localparam int CW  = $clog2(DIV);

  logic [CW-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (divCnt == CW'(DIV - 1)) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign tick = (divCnt == CW'(DIV - 1));

endmodule

// File: rtl/adcc_ctrl.sv
module adcc_ctrl
  import adcc_pkg::*;
#(
  parameter int ALE_W       = 2,
  parameter int SOC_W       = 2,
  parameter int OE_W        = 2,
  parameter int EOC_TIMEOUT = 20000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        eocIn,
  output logic        ale,
  output logic        soc,
  output logic        oe,
  output ctrlStrobe_t strobes
);
  localparam int ALE_EFF = (ALE_W < 2) ? 2 : ALE_W;
  localparam int SOC_EFF = (SOC_W < 2) ? 2 : SOC_W;
  localparam int OE_EFF  = (OE_W < 2) ? 2 : OE_W;
  localparam int PMAX    = (ALE_EFF > SOC_EFF) ? ((ALE_EFF > OE_EFF) ? ALE_EFF : OE_EFF)
                                               : ((SOC_EFF > OE_EFF) ? SOC_EFF : OE_EFF);
  localparam int PW      = $clog2(PMAX) + 1;
  localparam int TO_EFF  = (EOC_TIMEOUT < 2) ? 2 : EOC_TIMEOUT;
  localparam int TW      = $clog2(TO_EFF) + 1;

  ctrlState_t    state, stateNxt;
  logic [PW-1:0] phaseCnt;
  logic [TW-1:0] waitCnt;
  logic          phaseDone;

  always_comb begin
    case (state)
      ST_LATCH: phaseDone = (phaseCnt == PW'(ALE_EFF - 1));
      ST_START: phaseDone = (phaseCnt == PW'(SOC_EFF - 1));
      ST_READ:  phaseDone = (phaseCnt == PW'(OE_EFF - 1));
      default:  phaseDone = 1'b0;
    endcase
  end

  always_comb begin
    stateNxt = state;
    strobes  = '0;
    case (state)
      ST_IDLE: begin
        if (tick) begin
          stateNxt         = ST_SETUP;
          strobes.loadAddr = 1'b1;
        end
      end
      ST_SETUP: stateNxt = ST_LATCH;
      ST_LATCH: if (phaseDone) stateNxt = ST_START;
      ST_START: if (phaseDone) stateNxt = ST_WAIT;
      ST_WAIT: begin
        if (eocIn) begin
          stateNxt = ST_READ;
        end else if (waitCnt == TW'(TO_EFF - 1)) begin
          stateNxt        = ST_IDLE;
          strobes.timeout = 1'b1;
        end
      end
      ST_READ: begin
        if (phaseDone) begin
          stateNxt        = ST_IDLE;
          strobes.capture = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      waitCnt  <= '0;
    end else begin
      state <= stateNxt;
      if (stateNxt != state) begin
        phaseCnt <= '0;
        waitCnt  <= '0;
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
        if (state == ST_WAIT) waitCnt <= waitCnt + 1'b1;
      end
    end
  end

  assign ale = (state == ST_LATCH);
  assign soc = (state == ST_START);
  assign oe  = (state == ST_READ);

  // R4: read pulse only after end of conversion was seen
  assert_oe_after_eoc_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oe) |-> $past(eocIn));

  // R3: start of conversion directly follows the latch pulse
  assert_soc_follows_ale_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(soc) |-> $past(ale));

  // R7: a timeout is only taken while the converter is still busy
  assert_timeout_eoc_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.timeout |-> !eocIn);

  // R2: no new conversion begins unless idle
  assert_busy_drops_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> (state != ST_SETUP));

endmodule

// File: rtl/adcc_datapath.sv
module adcc_datapath
  import adcc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CH_W       = 3,
  parameter int SCAN_CHANS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobes,
  input  logic              ale,
  input  logic              soc,
  input  logic              oe,
  input  logic [CH_W-1:0]   chanSel,
  input  logic              autoScan,
  input  logic [DATA_W-1:0] adcData,
  output logic [CH_W-1:0]   adcAddr,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic [CH_W-1:0]   validChan,
  output logic              errFlag
);
  localparam int SCAN_EFF = (SCAN_CHANS < 1) ? 1 :
                            ((SCAN_CHANS > (1 << CH_W)) ? (1 << CH_W) : SCAN_CHANS);

  logic [CH_W-1:0] scanIdx;
  logic            busy;

  assign busy = ale || soc || oe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      adcAddr   <= '0;
      scanIdx   <= '0;
      dataOut   <= '0;
      dataValid <= 1'b0;
      validChan <= '0;
      errFlag   <= 1'b0;
    end else begin
      dataValid <= 1'b0;
      if (strobes.loadAddr) begin
        adcAddr <= autoScan ? scanIdx : chanSel;
        errFlag <= 1'b0;
      end else if (strobes.timeout) begin
        errFlag <= 1'b1;
      end
      if (strobes.capture) begin
        dataOut   <= adcData;
        dataValid <= 1'b1;
        validChan <= adcAddr;
        if (autoScan) begin
          scanIdx <= (scanIdx == CH_W'(SCAN_EFF - 1)) ? '0 : scanIdx + 1'b1;
        end
      end
    end
  end

  // R3: address held steady through the whole handshake
  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(adcAddr));

  // R6: valid strobe lasts a single clock
  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  // R5: capture coincides with the falling edge of oe
  assert_valid_at_oe_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> ($past(oe) && !oe));

  // R7: an error never comes together with a result
  assert_err_no_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !dataValid);

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adcc_pkg::*;
#(
  parameter int TICK_DIV    = 5000,
  parameter int ALE_W       = 2,
  parameter int SOC_W       = 2,
  parameter int OE_W        = 2,
  parameter int EOC_TIMEOUT = 20000,
  parameter int DATA_W      = 8,
  parameter int CH_W        = 3,
  parameter int SCAN_CHANS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eocIn,
  input  logic [DATA_W-1:0] adcData,
  input  logic [CH_W-1:0]   chanSel,
  input  logic              autoScan,
  output logic [CH_W-1:0]   adcAddr,
  output logic              ale,
  output logic              soc,
  output logic              oe,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic [CH_W-1:0]   validChan,
  output logic              errFlag
);
  logic        tick;
  ctrlStrobe_t strobes;

  adcc_tick #(.TICK_DIV(TICK_DIV)) uTick (
    .clk  (clk),
    .rstN (rstN),
    .tick (tick)
  );

  adcc_ctrl #(
    .ALE_W(ALE_W), .SOC_W(SOC_W), .OE_W(OE_W), .EOC_TIMEOUT(EOC_TIMEOUT)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .eocIn   (eocIn),
    .ale     (ale),
    .soc     (soc),
    .oe      (oe),
    .strobes (strobes)
  );

  adcc_datapath #(
    .DATA_W(DATA_W), .CH_W(CH_W), .SCAN_CHANS(SCAN_CHANS)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .ale       (ale),
    .soc       (soc),
    .oe        (oe),
    .chanSel   (chanSel),
    .autoScan  (autoScan),
    .adcData   (adcData),
    .adcAddr   (adcAddr),
    .dataOut   (dataOut),
    .dataValid (dataValid),
    .validChan (validChan),
    .errFlag   (errFlag)
  );

endmodule

// File: tb/tb_adc_conv_ctrl.sv
module tb_adc_conv_ctrl;
  localparam int TICK  = 40;
  localparam int AW    = 2;
  localparam int SW    = 3;
  localparam int OW    = 2;
  localparam int TOUT  = 60;
  localparam int NSCAN = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       eocIn = 1'b1;
  logic [7:0] adcData;
  logic [2:0] chanSel = 3'd6;
  logic       autoScan = 1'b1;
  logic [2:0] adcAddr;
  logic       ale, soc, oe, dataValid, errFlag;
  logic [7:0] dataOut;
  logic [2:0] validChan;

  always #5 clk = ~clk;

  adc_conv_ctrl #(
    .TICK_DIV(TICK), .ALE_W(AW), .SOC_W(SW), .OE_W(OW),
    .EOC_TIMEOUT(TOUT), .DATA_W(8), .CH_W(3), .SCAN_CHANS(NSCAN)
  ) dut (
    .clk(clk), .rstN(rstN), .eocIn(eocIn), .adcData(adcData),
    .chanSel(chanSel), .autoScan(autoScan), .adcAddr(adcAddr),
    .ale(ale), .soc(soc), .oe(oe), .dataOut(dataOut),
    .dataValid(dataValid), .validChan(validChan), .errFlag(errFlag)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // converter model settings
  int  convDelay = 8;
  bit  stall = 1'b0;
  bit  expectTimeout = 1'b0;
  bit  errSeen = 1'b0;
  bit  monitorOn = 1'b0;
  logic [7:0] convVal = 8'h00;
  assign adcData = oe ? convVal : 8'h00;

  logic [10:0] expQ[$];
  int  validCount = 0;
  int  benchScan = 0;
  int  cycle = 0;

  // model and monitor state
  bit  prevAle = 0, prevSoc = 0, prevOe = 0, prevEoc = 1, prevValid = 0, prevErr = 0;
  int  aleLen = 0, socLen = 0, oeLen = 0;
  int  lastAle = -1;
  bit  lastLong = 0;
  int  remain = 0;
  bit  stallNow = 0;
  int  seqNo = 0;
  int  oeRiseInConv = 0;
  bit  afterTimeout = 0;
  logic [2:0] startAddr = 0;

  always @(negedge clk) begin
    cycle++;
    if (monitorOn) begin
      // ALE rise: channel source, spacing, address setup
      if (ale && !prevAle) begin
        int expCh;
        expCh = autoScan ? benchScan : int'(chanSel);
        if (autoScan) check(adcAddr == 3'(expCh), "R9 scan channel", adcAddr, expCh);
        else          check(adcAddr == 3'(expCh), "R8 selected channel", adcAddr, expCh);
        if (lastAle >= 0)
          check(cycle - lastAle == (lastLong ? 2*TICK : TICK), "R2 start spacing",
                cycle - lastAle, lastLong ? 2*TICK : TICK);
        if (afterTimeout) begin
          check(errFlag == 1'b0, "R7 error cleared at new start", errFlag, 0);
          afterTimeout = 0;
        end
        lastAle   = cycle;
        lastLong  = stall || (convDelay > TICK - 10);
        startAddr = adcAddr;
        oeRiseInConv = 0;
      end
      if (ale) aleLen++;
      if (!ale && prevAle) begin
        check(aleLen == AW, "R3 ale width", aleLen, AW);
        aleLen = 0;
      end
      if (soc && !prevSoc) check(prevAle && !ale, "R3 soc follows ale", prevAle, 1);
      if (soc) socLen++;
      if (!soc && prevSoc) begin
        check(socLen == SW, "R3 soc width", socLen, SW);
        socLen = 0;
      end
      if (oe && !prevOe) begin
        oeRiseInConv++;
        check(prevEoc == 1'b1, "R4 oe after eoc", prevEoc, 1);
      end
      if (oe) oeLen++;
      if (!oe && prevOe) begin
        check(oeLen == OW, "R5 oe width", oeLen, OW);
        oeLen = 0;
      end
      // scoreboard monitor
      if (dataValid) begin
        check(!prevValid, "R6 single-clock valid", prevValid, 0);
        check(prevOe && !oe, "R5 capture at oe fall", prevOe, 1);
        if (expQ.size() == 0) begin
          check(1'b0, "R6 unexpected valid", 1, 0);
        end else begin
          logic [10:0] e;
          e = expQ.pop_front();
          check(dataOut == e[7:0], "R5 data", dataOut, e[7:0]);
          check(validChan == e[10:8] && validChan == startAddr, "R6 channel", validChan, e[10:8]);
        end
        validCount++;
        if (autoScan) benchScan = (benchScan + 1) % NSCAN;
      end
      if (errFlag && !prevErr) begin
        check(expectTimeout, "R7 timeout only when stalled", 0, 1);
        check(oeRiseInConv == 0 && expQ.size() == 0, "R7 no read on timeout", oeRiseInConv, 0);
        check(cycle - lastAle >= AW + SW + TOUT, "R7 timeout duration", cycle - lastAle, AW + SW + TOUT);
        errSeen = 1'b1;
        afterTimeout = 1'b1;
      end
    end
    // converter model
    if (soc && !prevSoc) begin
      eocIn    = 1'b0;
      remain   = convDelay;
      stallNow = stall;
    end else if (!eocIn && !stallNow) begin
      remain--;
      if (remain <= 0) begin
        seqNo++;
        convVal = {adcAddr, 5'(seqNo * 7 + 3)};
        expQ.push_back({adcAddr, convVal});
        eocIn = 1'b1;
      end
    end
    prevAle = ale; prevSoc = soc; prevOe = oe; prevEoc = eocIn;
    prevValid = dataValid; prevErr = errFlag;
  end

  task automatic waitValid(input int n);
    while (validCount < n) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    check(!ale && !soc && !oe, "R1 strobes low in reset", {ale, soc, oe}, 0);
    check(!dataValid && !errFlag, "R1 flags low in reset", {dataValid, errFlag}, 0);
    check(adcAddr == 0 && dataOut == 0 && validChan == 0, "R1 buses zero in reset", dataOut, 0);
    @(negedge clk);
    rstN = 1'b1;
    monitorOn = 1'b1;
    // scan mode, chanSel set to a value it must ignore (R9)
    waitValid(6);
    autoScan = 1'b0; chanSel = 3'd5;   // R8
    waitValid(9);
    chanSel = 3'd2;
    waitValid(11);
    convDelay = 45;                    // R2 dropped tick
    waitValid(14);
    convDelay = 8; stall = 1'b1; expectTimeout = 1'b1;   // R7
    while (!errSeen) @(negedge clk);
    repeat (5) @(negedge clk);
    check(errFlag == 1'b1, "R7 error held until next start", errFlag, 1);
    stall = 1'b0;
    waitValid(16);
    expectTimeout = 1'b0;
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R5 scoreboard drained", expQ.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    failures++;
    $display("FAIL watchdog expired valid=%0d expected=16", validCount);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule